// File: doc/BRIEF.md
# Adaptive-Length Bus Slot Allocator

This block hands out time slots on a shared bus among a group of cores. A slot pointer walks through slot positions 0, 1, 2 and so on. When it has served the position of the highest core that has raised its participation flag, it wraps back to 0. Idle upper cores therefore shorten the rotation instead of wasting bus cycles, and the rotation length can be any value from 1 to the core count.

Each slot position belongs to one core. That core nominates a receiver for its slot with a target ID, which can be itself or any other core. A slot is granted only if its receiver is requesting; otherwise that bus cycle is idle. Two mechanisms keep the behaviour predictable:

- The control fields are captured in registers only at a rotation boundary, so no decode path reaches the grant logic.
- A compatibility bit restores a fixed full-length rotation in which every core owns its own slot.

Top module: `slot_alloc`

## Requirements
- R1: While rst_ni is low, grant_o is all zeros, grant_id_o is 0 and grant_vld_o is 0. The first rotation after reset has 16 slots, and each slot p goes to core p, whatever the control inputs are.
- R2: With compat_i low, a rotation serves positions 0 up to the highest index set in the captured use flags, so its length is that index plus one. With only flag 8 set, a given slot recurs every 9 clocks.
- R3: The slot at position p is granted to core target_i[4p+3:4p], as captured, only if that core's req_i bit is high; otherwise no grant is issued. A cleared use flag below the top flag does not remove position p from the rotation.
- R4: grant_o has at most one bit set. When a bit k is set, grant_id_o equals k and grant_vld_o is 1. When grant_o is all zeros, grant_vld_o is 0.
- R5: With compat_i captured high, the rotation is 16 slots long and slot p goes to core p, whatever the use flags and targets are.
- R6: use_i, target_i and compat_i are captured only when the last position of a rotation is served. A change in the middle of a rotation alters neither its length nor its owners.
- R7: With compat_i low and no use flag captured, no grant is issued.
- R8: The grant for a slot appears on the outputs one clock after the slot is served, and it reflects req_i as sampled at the clock edge that ends that slot.
- R9: If every slot names one core, that core can be granted on every clock. If the slots alternate between two cores, each of those cores receives half of the clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| use_i | input | 16 | Per-core participation flag; the highest set bit fixes the rotation length |
| target_i | input | 64 | Per-core 4-bit receiver ID; nibble p names the receiver of slot p |
| compat_i | input | 1 | Forces a fixed 16-slot rotation with every core owning its own slot |
| req_i | input | 16 | Per-core bus request |
| grant_o | output | 16 | One-hot registered grant |
| grant_id_o | output | 4 | ID of the granted core (0 when there is no grant) |
| grant_vld_o | output | 1 | A grant is present this clock |

## Verification
Several behaviours are checked by assertions on every cycle:

- the grant is one-hot and agrees with the ID and valid outputs;
- every grant goes to a core that was requesting on the previous clock;
- the pointer never passes the last position and wraps right after it;
- the captured configuration stays constant within a rotation;
- no grant is issued when the captured configuration is empty.

Other behaviours can only be shown by the bench's scenarios. These are the exact rotation length and recurrence interval, donation of slots to other cores, the full-rate and half-rate sharing cases, the fixed compatibility order, and the delay of a changed configuration until the wrap.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  localparam int unsigned DEF_CORES = 16;
endpackage

// File: rtl/slot_cfg_regs.sv
module slot_cfg_regs #(
  parameter int unsigned NUM_CORES = slot_alloc_pkg::DEF_CORES,
  localparam int unsigned ID_W = $clog2(NUM_CORES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [NUM_CORES-1:0]      use_i,
  input  logic [NUM_CORES*ID_W-1:0] tgt_i,
  input  logic                      compat_i,
  output logic [NUM_CORES-1:0]      use_o,
  output logic [NUM_CORES*ID_W-1:0] tgt_o,
  output logic                      compat_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        use_o[c]               <= 1'b1;
        tgt_o[c*ID_W +: ID_W]  <= ID_W'(c);
      end else if (load_i) begin
        use_o[c]               <= use_i[c];
        tgt_o[c*ID_W +: ID_W]  <= tgt_i[c*ID_W +: ID_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     compat_o <= 1'b0;
    else if (load_i) compat_o <= compat_i;
  end
endmodule

// File: rtl/slot_top_enc.sv
module slot_top_enc #(
  parameter int unsigned NUM_CORES = slot_alloc_pkg::DEF_CORES,
  localparam int unsigned ID_W = $clog2(NUM_CORES)
) (
  input  logic [NUM_CORES-1:0] use_i,
  output logic [ID_W-1:0]      top_o,
  output logic                 any_o
);
  always_comb begin
    top_o = '0;
    for (int unsigned i = 0; i < NUM_CORES; i++) begin
      if (use_i[i]) top_o = ID_W'(i);
    end
    any_o = |use_i;
  end
endmodule

// File: rtl/slot_grant.sv
module slot_grant #(
  parameter int unsigned NUM_CORES = slot_alloc_pkg::DEF_CORES,
  localparam int unsigned ID_W = $clog2(NUM_CORES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ID_W-1:0]           pos_i,
  input  logic [NUM_CORES*ID_W-1:0] tgt_i,
  input  logic                      compat_i,
  input  logic                      active_i,
  input  logic [NUM_CORES-1:0]      req_i,
  output logic [NUM_CORES-1:0]      grant_o,
  output logic [ID_W-1:0]           grant_id_o,
  output logic                      grant_vld_o
);
  logic [ID_W-1:0] id_d;
  logic            vld_d;

  always_comb begin
    id_d  = compat_i ? pos_i : tgt_i[int'(pos_i)*ID_W +: ID_W];
    vld_d = active_i && req_i[id_d];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o     <= '0;
      grant_id_o  <= '0;
      grant_vld_o <= 1'b0;
    end else begin
      grant_o     <= vld_d ? (NUM_CORES'(1) << id_d) : '0;
      grant_id_o  <= vld_d ? id_d : '0;
      grant_vld_o <= vld_d;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));                                                   // R4
  AST_GRANT_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> grant_o[grant_id_o]);                                 // R4
  AST_VLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_vld_o |-> (grant_o == '0));                                    // R4
  AST_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> |($past(req_i) & grant_o));                           // R3
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
  parameter int unsigned NUM_CORES = slot_alloc_pkg::DEF_CORES,
  localparam int unsigned ID_W = $clog2(NUM_CORES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CORES-1:0]      use_i,
  input  logic [NUM_CORES*ID_W-1:0] target_i,
  input  logic                      compat_i,
  input  logic [NUM_CORES-1:0]      req_i,
  output logic [NUM_CORES-1:0]      grant_o,
  output logic [ID_W-1:0]           grant_id_o,
  output logic                      grant_vld_o
);
  logic [NUM_CORES-1:0]      use_q;
  logic [NUM_CORES*ID_W-1:0] tgt_q;
  logic                      compat_q;
  logic [ID_W-1:0]           top;
  logic                      any_use;
  logic [ID_W-1:0]           pos_q;
  logic [ID_W-1:0]           last;
  logic                      wrap;

  // config only moves at the rotation boundary
  slot_cfg_regs #(.NUM_CORES(NUM_CORES)) u_cfg (
    .clk_i, .rst_ni, .load_i(wrap),
    .use_i, .tgt_i(target_i), .compat_i,
    .use_o(use_q), .tgt_o(tgt_q), .compat_o(compat_q)
  );

  slot_top_enc #(.NUM_CORES(NUM_CORES)) u_enc (
    .use_i(use_q), .top_o(top), .any_o(any_use)
  );

  assign last = compat_q ? ID_W'(NUM_CORES-1) : top;
  assign wrap = (pos_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pos_q <= '0;
    else if (wrap) pos_q <= '0;
    else           pos_q <= pos_q + 1'b1;
  end

  slot_grant #(.NUM_CORES(NUM_CORES)) u_grant (
    .clk_i, .rst_ni, .pos_i(pos_q), .tgt_i(tgt_q), .compat_i(compat_q),
    .active_i(compat_q | any_use), .req_i,
    .grant_o, .grant_id_o, .grant_vld_o
  );

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= last);                                                       // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (pos_q == '0));                                              // R2
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> ($stable(use_q) && $stable(tgt_q) && $stable(compat_q)));   // R6
  AST_IDLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!compat_q && !any_use) |=> !grant_vld_o);                            // R7
endmodule

// File: tb/slot_alloc_tb.sv
`timescale 1ns/1ps
module slot_alloc_tb;
  localparam int unsigned N = 16;
  localparam logic [63:0] SELF = 64'hFEDCBA9876543210;

  typedef struct packed {
    logic [15:0] use_m;
    logic [63:0] tgt;
    logic [15:0] req;
    logic        compat;
    logic [7:0]  cycles;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h0100, SELF,                  16'hFFFF, 1'b0, 8'd40},
    '{16'h0100, 64'h3333333333333333,  16'h0008, 1'b0, 8'd30},
    '{16'h0002, 64'hFEDCBA9876543221,  16'h0006, 1'b0, 8'd24},
    '{16'h0000, 64'h3333333333333333,  16'hFFFF, 1'b1, 8'd40},
    '{16'h0000, SELF,                  16'hFFFF, 1'b0, 8'd12},
    '{16'h8421, 64'h0123456789ABCDEF,  16'h5555, 1'b0, 8'd40}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] use_r = '0;
  logic [63:0] tgt_r = SELF;
  logic        compat_r = 1'b0;
  logic [15:0] req_r = '0;
  logic [15:0] grant;
  logic [3:0]  grant_id;
  logic        grant_vld;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int          m_pos;
  logic [15:0] m_use;
  logic [63:0] m_tgt;
  logic        m_compat;

  always #2.5 clk = ~clk;

  slot_alloc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .use_i(use_r), .target_i(tgt_r),
    .compat_i(compat_r), .req_i(req_r),
    .grant_o(grant), .grant_id_o(grant_id), .grant_vld_o(grant_vld)
  );

  function automatic int top_of(logic [15:0] u);
    int t = 0;
    for (int i = 0; i < 16; i++) if (u[i]) t = i;
    return t;
  endfunction

  task automatic check(string tag, logic ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pos = 0; m_use = 16'hFFFF; m_tgt = SELF; m_compat = 1'b0;
  endtask

  // one clock against the reference; R4 consistency checked every step
  task automatic step(string tag);
    int          last, id;
    logic        act, ev;
    logic [15:0] exp_g;
    last  = m_compat ? 15 : ((m_use == 0) ? 0 : top_of(m_use));
    id    = m_compat ? m_pos : int'(m_tgt[m_pos*4 +: 4]);
    act   = m_compat || (m_use != 0);
    ev    = act && req_r[id];
    exp_g = ev ? (16'h1 << id) : 16'h0;
    if (m_pos == last) begin
      m_pos = 0; m_use = use_r; m_tgt = tgt_r; m_compat = compat_r;
    end else m_pos++;
    @(posedge clk); #1;
    check(tag, grant == exp_g, "grant", int'(grant), int'(exp_g));
    check("R4", $onehot0(grant) && (grant_vld == (grant != 0)) &&
          (!grant_vld || grant[grant_id]), "consistency", int'(grant), int'(grant_id));
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int last_t, gap;
    // R1 reset state, inputs busy
    use_r = 16'h0003; tgt_r = 64'h3333333333333333; req_r = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1", grant == 0 && grant_id == 0 && !grant_vld, "reset outputs",
          int'(grant), 0);
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    // R1 first rotation is 16 self-owned slots
    for (int i = 0; i < 16; i++) begin
      step("R1");
      check("R1", grant_id == 4'(i), "first rotation id", int'(grant_id), i);
    end

    // table walk
    for (int v = 0; v < 6; v++) begin
      use_r = VEC[v].use_m; tgt_r = VEC[v].tgt; req_r = VEC[v].req;
      compat_r = VEC[v].compat;
      for (int c = 0; c < int'(VEC[v].cycles); c++)
        step(VEC[v].compat ? "R5" : (VEC[v].use_m == 0 ? "R7" :
             (VEC[v].tgt == SELF ? "R2" : "R3")));
    end

    // R2 recurrence: only core 8 used and requesting
    use_r = 16'h0100; tgt_r = SELF; req_r = 16'h0100; compat_r = 1'b0;
    repeat (20) step("R2");
    last_t = -1; gap = 0;
    for (int c = 0; c < 30; c++) begin
      step("R2");
      if (grant_vld) begin
        if (last_t >= 0) begin gap = c - last_t;
          check("R2", gap == 9, "recurrence", gap, 9); end
        last_t = c;
      end
    end

    // R9 all slots to core 3: every clock granted
    use_r = 16'h0100; tgt_r = 64'h3333333333333333; req_r = 16'h0008;
    repeat (20) step("R9");
    for (int c = 0; c < 18; c++) begin
      step("R9");
      check("R9", grant_vld && grant_id == 4'd3, "full rate", int'(grant_id), 3);
    end
    // R9 two cores alternate
    use_r = 16'h0002; tgt_r = 64'hFEDCBA9876543221; req_r = 16'h0006;
    repeat (12) step("R9");
    for (int c = 0; c < 10; c++) begin
      step("R9");
      check("R9", grant_vld && (grant_id == 4'd1 || grant_id == 4'd2),
            "half rate", int'(grant_id), 1);
    end

    // R6 mid-rotation change: full rotation, then shrink partway
    use_r = 16'hFFFF; tgt_r = SELF; req_r = 16'hFFFF;
    repeat (40) step("R6");
    use_r = 16'h0003;
    repeat (40) step("R6");

    // R8 request toggling every clock
    use_r = 16'h00FF; tgt_r = SELF;
    for (int c = 0; c < 40; c++) begin
      req_r = (c % 2 == 0) ? 16'h5555 : 16'hAAAA;
      step("R8");
    end

    // R1 reset again mid-traffic
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1", grant == 0 && !grant_vld, "async reset", int'(grant), 0);
    @(negedge clk); rst_n = 1'b1; model_reset();
    repeat (16) step("R1");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule